// File: doc/BRIEF.md
# SMM Memory Region Decoder with Configuration Lock

This block guards a protected memory window for system management mode. The window is cut from the top of low DRAM. Software picks its size and turns it on through one small configuration register. The block then classifies every memory request. A request either continues to DRAM or is sent to the downstream I/O link. Only the processor, while it runs in system management mode, may reach DRAM inside the window. Every other access that lands inside the window is turned away to the link.

Software can set a lock bit in the same register. Once the lock is set, the size and the enable can no longer change until the next reset, so code that runs later cannot reopen or shrink the window. The top-of-low-DRAM boundary and a global enable come in from outside the block. A registered routing decision comes out one clock after each request.

Top module: `smm_region_decoder`

## Requirements
- R1: After reset the window enable (bit 0) reads 0, the size code (bits 2:1) reads 00 and the lock (bit 4) reads 0, so `cfg_rdata` reads 8'h08.
- R2: The window spans from `tolud` minus the selected size up to `tolud`, with `tolud` excluded. The size codes are 00 for 1 MB, 01 for 2 MB and 10 for 8 MB.
- R3: The window is active only while `smram_glb_en` is 1 and the enable bit is 1.
- R4: A request inside an active window that has both `req_cpu` and `req_smm` set goes to DRAM: `dec_hit` is 1 and `dec_to_link` is 0.
- R5: Any other request inside an active window goes to the I/O link: `dec_hit` is 1 and `dec_to_link` is 1. This covers a non-SMM request, and it also covers an SMM request from an agent other than the processor.
- R6: A request outside the window, or any request while the window is inactive, goes to DRAM: `dec_hit` is 0 and `dec_to_link` is 0.
- R7: Writing 1 to bit 4 sets the lock. Writing 0 to it does not clear it; only reset clears it. While the lock is set, writes leave the enable and the size unchanged. A write that sets the lock while the lock is still clear also updates the enable and the size.
- R8: Bit 3 is a cache status bit. It always reads 1, and writes have no effect on it.
- R9: Size code 11 is reserved. While it is programmed the window is inactive and no request is decoded into it.
- R10: The decision appears on `dec_valid`, `dec_hit` and `dec_to_link` one clock after a request is accepted. `dec_valid` is 0 in any cycle that follows a clock with no request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| cfg_we | input | 1 | Write strobe for the configuration register |
| cfg_wdata | input | 8 | Write data |
| cfg_rdata | output | 8 | Current value of the configuration register |
| tolud | input | 36 | Top of low DRAM, byte address, aligned to 1 MB |
| smram_glb_en | input | 1 | Global SMRAM enable |
| req_valid | input | 1 | A request is present this cycle |
| req_addr | input | 36 | Byte address of the request |
| req_cpu | input | 1 | The request comes from the processor |
| req_smm | input | 1 | The request is marked as system management mode |
| dec_valid | output | 1 | A decision is present |
| dec_hit | output | 1 | The request fell inside the active window |
| dec_to_link | output | 1 | 1 sends the request to the I/O link, 0 sends it to DRAM |

## Verification
The bench builds the block with its default parameters: a 36-bit address and a 1 MB size unit. The 36-bit width lets the bench drive requests above 4 GB, and those requests must never be decoded into the window. With a 1 MB unit, the window edges for all three legal sizes sit at exact byte addresses below a 2 GB boundary. The bench probes the first byte of each window, its last byte, and the byte just past each end.

// File: rtl/smrd_pkg.sv
package smrd_pkg;
  typedef enum logic [1:0] {
    SZ_1M   = 2'b00,
    SZ_2M   = 2'b01,
    SZ_8M   = 2'b10,
    SZ_RSVD = 2'b11
  } rgn_size_e;

  localparam int unsigned BIT_EN    = 0;
  localparam int unsigned BIT_SZ_LO = 1;
  localparam int unsigned BIT_SZ_HI = 2;
  localparam int unsigned BIT_CACHE = 3;
  localparam int unsigned BIT_LOCK  = 4;

  // Window size in size units (1 unit = 2**UNIT_SHIFT bytes); 0 means none.
  function automatic int unsigned size_units(rgn_size_e code);
    case (code)
      SZ_1M:   return 1;
      SZ_2M:   return 2;
      SZ_8M:   return 8;
      default: return 0;
    endcase
  endfunction
endpackage

// File: rtl/smrd_cfg_regs.sv
module smrd_cfg_regs
  import smrd_pkg::*;
#(
  parameter int CFG_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cfg_we,
  input  logic [CFG_W-1:0] cfg_wdata,
  output logic [CFG_W-1:0] cfg_rdata,
  output logic             rgn_en,
  output rgn_size_e        rgn_size,
  output logic             locked
);
  logic      en_q;
  rgn_size_e sz_q;
  logic      lock_q;

  // Named events for the assertions.
  logic wr_open, wr_blocked, lock_req;
  assign wr_open    = cfg_we && !lock_q;
  assign wr_blocked = cfg_we && lock_q;
  assign lock_req   = cfg_we && cfg_wdata[BIT_LOCK];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_q   <= 1'b0;
      sz_q   <= SZ_1M;
      lock_q <= 1'b0;
    end else begin
      if (wr_open) begin
        en_q <= cfg_wdata[BIT_EN];
        sz_q <= rgn_size_e'(cfg_wdata[BIT_SZ_HI:BIT_SZ_LO]);
      end
      if (lock_req) lock_q <= 1'b1;
    end
  end

  always_comb begin
    cfg_rdata                      = '0;
    cfg_rdata[BIT_EN]              = en_q;
    cfg_rdata[BIT_SZ_HI:BIT_SZ_LO] = sz_q;
    cfg_rdata[BIT_CACHE]           = 1'b1;
    cfg_rdata[BIT_LOCK]            = lock_q;
  end

  assign rgn_en   = en_q;
  assign rgn_size = sz_q;
  assign locked   = lock_q;

  p_frozen_r7: assert property (@(posedge clk) disable iff (!rst_n)
    wr_blocked |=> $stable(en_q) && $stable(sz_q));
  p_lock_sticky_r7: assert property (@(posedge clk) disable iff (!rst_n)
    lock_q |=> lock_q);
  p_lock_set_r7: assert property (@(posedge clk) disable iff (!rst_n)
    lock_req |=> lock_q);
endmodule

// File: rtl/smrd_window.sv
module smrd_window
  import smrd_pkg::*;
#(
  parameter int ADDR_W     = 36,
  parameter int UNIT_SHIFT = 20
) (
  input  logic              glb_en,
  input  logic              rgn_en,
  input  rgn_size_e         rgn_size,
  input  logic [ADDR_W-1:0] top,
  input  logic [ADDR_W-1:0] addr,
  output logic              active,
  output logic              hit
);
  localparam int XW = ADDR_W + 1;

  // Lower edge of the window. It is clamped at 0 if the window is
  // larger than the boundary.
  function automatic logic [XW-1:0] win_base(logic [ADDR_W-1:0] t, rgn_size_e c);
    logic [XW-1:0] span;
    logic [XW-1:0] tx;
    span = XW'(size_units(c)) << UNIT_SHIFT;
    tx   = {1'b0, t};
    if (span > tx) return '0;
    return tx - span;
  endfunction

  logic [XW-1:0] base;
  logic          above_base, below_top;

  assign base       = win_base(top, rgn_size);
  assign above_base = {1'b0, addr} >= base;
  assign below_top  = addr < top;
  assign active     = glb_en && rgn_en && (rgn_size != SZ_RSVD);
  assign hit        = active && above_base && below_top;
endmodule

// File: rtl/smrd_route.sv
module smrd_route (
  input  logic clk,
  input  logic rst_n,
  input  logic req_valid,
  input  logic in_win,
  input  logic req_cpu,
  input  logic req_smm,
  output logic dec_valid,
  output logic dec_hit,
  output logic dec_to_link
);
  logic smm_grant, redirect;
  assign smm_grant = in_win && req_cpu && req_smm;
  assign redirect  = in_win && !smm_grant;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dec_valid   <= 1'b0;
      dec_hit     <= 1'b0;
      dec_to_link <= 1'b0;
    end else begin
      dec_valid   <= req_valid;
      dec_hit     <= req_valid && in_win;
      dec_to_link <= req_valid && redirect;
    end
  end

  p_smm_dram_r4: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid && in_win && req_cpu && req_smm |=> dec_valid && dec_hit && !dec_to_link);
  p_redirect_r5: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid && in_win && !(req_cpu && req_smm) |=> dec_valid && dec_hit && dec_to_link);
  p_outside_r6: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid && !in_win |=> dec_valid && !dec_hit && !dec_to_link);
  p_idle_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !req_valid |=> !dec_valid && !dec_hit && !dec_to_link);
endmodule

// File: rtl/smm_region_decoder.sv
module smm_region_decoder
  import smrd_pkg::*;
#(
  parameter int ADDR_W     = 36,
  parameter int UNIT_SHIFT = 20,
  parameter int CFG_W      = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_we,
  input  logic [CFG_W-1:0]  cfg_wdata,
  output logic [CFG_W-1:0]  cfg_rdata,
  input  logic [ADDR_W-1:0] tolud,
  input  logic              smram_glb_en,
  input  logic              req_valid,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic              req_cpu,
  input  logic              req_smm,
  output logic              dec_valid,
  output logic              dec_hit,
  output logic              dec_to_link
);
  logic      rgn_en, locked, win_active, win_hit;
  rgn_size_e rgn_size;

  smrd_cfg_regs #(.CFG_W(CFG_W)) u_regs (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_wdata(cfg_wdata),
    .cfg_rdata(cfg_rdata), .rgn_en(rgn_en), .rgn_size(rgn_size), .locked(locked)
  );

  smrd_window #(.ADDR_W(ADDR_W), .UNIT_SHIFT(UNIT_SHIFT)) u_win (
    .glb_en(smram_glb_en), .rgn_en(rgn_en), .rgn_size(rgn_size), .top(tolud),
    .addr(req_addr), .active(win_active), .hit(win_hit)
  );

  smrd_route u_route (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .in_win(win_hit),
    .req_cpu(req_cpu), .req_smm(req_smm), .dec_valid(dec_valid),
    .dec_hit(dec_hit), .dec_to_link(dec_to_link)
  );

  p_bounds_r2: assert property (@(posedge clk) disable iff (!rst_n)
    win_hit |-> req_addr < tolud);
  p_inactive_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !(smram_glb_en && rgn_en) |-> !win_hit && !win_active);
  p_reserved_r9: assert property (@(posedge clk) disable iff (!rst_n)
    rgn_size == SZ_RSVD |-> !win_hit);
  p_lock_holds_r7: assert property (@(posedge clk) disable iff (!rst_n)
    locked && cfg_we |=> $stable(rgn_en) && $stable(rgn_size));
endmodule

// File: tb/test_smm_region_decoder.sv
module test_smm_region_decoder;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cfg_we = 1'b0;
  logic [7:0]  cfg_wdata = '0;
  logic [7:0]  cfg_rdata;
  logic [35:0] tolud = 36'h0_8000_0000;
  logic        smram_glb_en = 1'b0;
  logic        req_valid = 1'b0;
  logic [35:0] req_addr = '0;
  logic        req_cpu = 1'b0;
  logic        req_smm = 1'b0;
  logic        dec_valid, dec_hit, dec_to_link;

  int checks = 0;
  int fails  = 0;

  always #4 clk = ~clk;  // 125 MHz

  smm_region_decoder i_smm_region_decoder (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_wdata(cfg_wdata),
    .cfg_rdata(cfg_rdata), .tolud(tolud), .smram_glb_en(smram_glb_en),
    .req_valid(req_valid), .req_addr(req_addr), .req_cpu(req_cpu),
    .req_smm(req_smm), .dec_valid(dec_valid), .dec_hit(dec_hit),
    .dec_to_link(dec_to_link)
  );

  // {addr[35:0], cpu, smm, exp_hit, exp_link}; window 2 MB below 2 GB
  localparam logic [39:0] VEC [10] = '{
    {36'h0_7FE0_0000, 4'b1110},  // R4 first byte, SMM cpu
    {36'h0_7FFF_FFFF, 4'b1110},  // R4 last byte
    {36'h0_8000_0000, 4'b1000},  // R6 boundary excluded
    {36'h0_7FDF_FFFF, 4'b1000},  // R6 below window
    {36'h0_7FF0_0000, 4'b1011},  // R5 cpu non-SMM
    {36'h0_7FF0_0000, 4'b0111},  // R5 non-cpu with SMM
    {36'h0_7FE0_0000, 4'b0011},  // R5 non-cpu non-SMM
    {36'h0_0000_1000, 4'b1100},  // R6 low address
    {36'h8_7FF0_0000, 4'b1000},  // R6 above 4 GB
    {36'h0_7FFF_FFFF, 4'b0011}   // R5 last byte redirect
  };

  task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic cfg_write(input logic [7:0] d);
    @(negedge clk);
    cfg_we = 1'b1; cfg_wdata = d;
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  // Drive one request, sample the registered decision one clock later.
  task automatic do_req(input string req, input logic [35:0] a, input logic c,
                        input logic s, input logic eh, input logic el);
    @(negedge clk);
    req_valid = 1'b1; req_addr = a; req_cpu = c; req_smm = s;
    @(negedge clk);
    req_valid = 1'b0;
    check(req, {5'b0, dec_valid, dec_hit, dec_to_link}, {5'b0, 1'b1, eh, el});
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    fails++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1 reset value", cfg_rdata, 8'h08);
    check("R10 no request", {7'b0, dec_valid}, 8'h00);

    // Enabled, 2 MB, global on
    smram_glb_en = 1'b1;
    cfg_write(8'h03);
    check("R2 readback", cfg_rdata, 8'h0B);
    for (int i = 0; i < 10; i++)
      do_req("R2/R4/R5/R6 table", VEC[i][39:4], VEC[i][3], VEC[i][2], VEC[i][1], VEC[i][0]);
    @(negedge clk);
    check("R10 idle after request", {7'b0, dec_valid}, 8'h00);

    // 1 MB edges
    cfg_write(8'h01);
    do_req("R2 1MB first byte", 36'h0_7FF0_0000, 1'b0, 1'b0, 1'b1, 1'b1);
    do_req("R2 1MB below", 36'h0_7FEF_FFFF, 1'b0, 1'b0, 1'b0, 1'b0);
    // 8 MB edges
    cfg_write(8'h05);
    do_req("R2 8MB first byte", 36'h0_7F80_0000, 1'b0, 1'b0, 1'b1, 1'b1);
    do_req("R2 8MB below", 36'h0_7F7F_FFFF, 1'b0, 1'b0, 1'b0, 1'b0);

    // Global enable off
    smram_glb_en = 1'b0;
    do_req("R3 global off", 36'h0_7FF0_0000, 1'b0, 1'b0, 1'b0, 1'b0);
    smram_glb_en = 1'b1;
    // Region enable off
    cfg_write(8'h04);
    do_req("R3 region off", 36'h0_7FF0_0000, 1'b0, 1'b0, 1'b0, 1'b0);
    // Reserved size
    cfg_write(8'h07);
    check("R9 readback", cfg_rdata, 8'h0F);
    do_req("R9 reserved size", 36'h0_7FF0_0000, 1'b0, 1'b0, 1'b0, 1'b0);

    // Cache bit ignores writes
    cfg_write(8'h03);
    check("R8 cache bit reads 1", cfg_rdata, 8'h0B);

    // Lock together with settings: 2 MB enabled
    cfg_write(8'h13);
    check("R7 lock set", cfg_rdata, 8'h1B);
    cfg_write(8'h05);
    check("R7 writes ignored when locked", cfg_rdata, 8'h1B);
    do_req("R7 window still 2MB", 36'h0_7FD0_0000, 1'b0, 1'b0, 1'b0, 1'b0);
    do_req("R7 window still on", 36'h0_7FE0_0000, 1'b0, 1'b0, 1'b1, 1'b1);
    cfg_write(8'h00);
    check("R7 lock not cleared by write", cfg_rdata, 8'h1B);

    // Reset clears lock
    @(negedge clk);
    rst_n = 1'b0;
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1 R7 reset clears lock", cfg_rdata, 8'h08);
    do_req("R6 after reset", 36'h0_7FF0_0000, 1'b0, 1'b0, 1'b0, 1'b0);

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule